// File: doc/BRIEF.md
# Configuration Session Sequencer

This block supervises one configuration session of a programmable device. A configuration port hands it register writes, each a 5-bit register address and a 32-bit data word, one per cycle. The block accepts the session only if the steps arrive in a set order. First the device identity must match a fixed value. Then the setup options must be written. After that, a start frame address, a write-configuration command and whole frames of data words follow. Last comes a restart ritual that activates the configuration flip-flops, releases the interconnect, arms startup and desynchronizes the port.

Every register write is folded into a running CRC. A write to the CRC register checks the folded value. A bad identity, a CRC mismatch or any step out of order raises a sticky error. The error freezes the sequencer until reset, so no further frame data is accepted. After desynchronization, an eight-phase startup counter advances once per startup clock-enable pulse and then reports completion. A 16-bit status word shows the phase of the session and which control levels are active.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After synchronous reset every output is low or zero: status is 0 (session phase 0, waiting for identity), and frame_addr and word_idx are 0.
- R2: A write of DEVICE_ID to register 12 while waiting for identity moves the session phase to 1 (setup). Any other value sets the error bit and leaves the phase at 0.
- R3: In setup, writes to register 9 set sticky flags from data bits 0 (watchdog off), 1 (startup clock chosen), 2 (startup timing set) and 3 (interconnect high impedance). Output wdog_off follows flag 0 and ic_hiz follows flag 3. A frame address write (register 1) made before all four flags are set raises the error.
- R4: The order must be: frame address write (phase 1 to 2), then command 1 on register 4 (phase 2 to 3), then data words on register 2. A command 1 outside phase 2, a data word outside phase 3, an identity write outside phase 0 or an option write outside phase 1 raises the error.
- R5: Each accepted data word pulses frame_word_ok for one cycle and advances word_idx. After word index 100 (the 101st word of a frame), word_idx wraps to 0 and frame_addr increments by one from the loaded start address.
- R6: Command 10 is accepted only in phase 3 with word_idx at 0 and at least one full frame written. It pulses ff_activate, drops ic_hiz and moves to phase 4. At any other point it raises the error.
- R7: Command 5 in phase 4 arms startup (status bit 10) and moves to phase 5. Command 13 in phase 5 pulses desync and moves to phase 6. Either command in any other phase raises the error.
- R8: In phase 6 each stup_tick advances the startup phase (status bits 5:3) from 0 up to 7. The eighth tick sets stup_done (status bit 6). Ticks in earlier phases have no effect.
- R9: The CRC starts at 0 and is updated for every write except CRC-register writes and command 3. It shifts in the 37-bit value {address, data} most significant bit first, using polynomial 0x1EDC6F41, with no reflection and no final inversion. A write to register 0 whose data differs from the current CRC raises the error.
- R10: Command 3 clears the CRC to 0.
- R11: The error (status bit 7) stays set until reset. Once it is set, no write changes the phase, pulses frame_word_ok or drives any strobe.
- R12: Status layout: bits 2:0 session phase, 5:3 startup phase, 6 done, 7 error, 8 watchdog off, 9 interconnect high impedance, 10 startup armed, 15:11 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write valid this cycle |
| wr_addr | input | 5 | Register address |
| wr_data | input | 32 | Register write data |
| stup_tick | input | 1 | Startup clock enable pulse |
| wdog_off | output | 1 | Watchdog disable level |
| ic_hiz | output | 1 | Interconnect high-impedance level |
| ff_activate | output | 1 | One-cycle configuration flip-flop activation strobe |
| desync | output | 1 | One-cycle desynchronization strobe |
| frame_word_ok | output | 1 | One-cycle pulse per accepted frame data word |
| frame_addr | output | 32 | Current frame address |
| word_idx | output | 7 | Word position within the current frame |
| stup_done | output | 1 | Startup sequence complete |
| status | output | 16 | Session status word |

## Verification
The hardest states to reach are the restart checks at a frame boundary. The activation command is legal only after at least one whole 101-word frame and with no partial frame pending. Startup can run only after the full legal path before it. The bench therefore drives a complete session with two full frames, keeping a bit-serial CRC model alongside, and then runs all eight startup ticks. Separate short sessions stop partway through a frame, or break the order at one chosen step, and then confirm that later data is refused.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int WORD_W = ADDR_W + DATA_W;

    localparam logic [ADDR_W-1:0] RA_CRC = 5'd0;
    localparam logic [ADDR_W-1:0] RA_FAR = 5'd1;
    localparam logic [ADDR_W-1:0] RA_FDI = 5'd2;
    localparam logic [ADDR_W-1:0] RA_CMD = 5'd4;
    localparam logic [ADDR_W-1:0] RA_OPT = 5'd9;
    localparam logic [ADDR_W-1:0] RA_ID  = 5'd12;

    localparam logic [4:0] CMD_WCFG   = 5'd1;
    localparam logic [4:0] CMD_RCRC   = 5'd3;
    localparam logic [4:0] CMD_START  = 5'd5;
    localparam logic [4:0] CMD_ACT    = 5'd10;
    localparam logic [4:0] CMD_DESYNC = 5'd13;

    localparam logic [DATA_W-1:0] CRC_POLY = 32'h1EDC6F41;

    typedef enum logic [2:0] {
        PH_WAIT_ID = 3'd0,
        PH_SETUP   = 3'd1,
        PH_ADDR    = 3'd2,
        PH_WRITE   = 3'd3,
        PH_ACTIVE  = 3'd4,
        PH_ARMED   = 3'd5,
        PH_STARTUP = 3'd6
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cfg_wr_t;

    function automatic logic [DATA_W-1:0] crc_fold(input logic [DATA_W-1:0] c,
                                                   input logic [WORD_W-1:0] v);
        logic [DATA_W-1:0] r;
        logic fb;
        r = c;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = r[DATA_W-1] ^ v[i];
            r  = {r[DATA_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction
endpackage

// File: rtl/cfg_crc_acc.sv
module cfg_crc_acc
    import cfg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fold,
    input  logic              clear,
    input  cfg_wr_t           wr,
    output logic [DATA_W-1:0] crc_q
);
    always_ff @(posedge clk) begin
        if (rst || clear) crc_q <= '0;
        else if (fold)    crc_q <= crc_fold(crc_q, wr);
    end

    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $past(clear) |-> crc_q == '0);
endmodule

// File: rtl/cfg_frame_ctr.sv
module cfg_frame_ctr
    import cfg_seq_pkg::*;
#(
    parameter int FRAME_WORDS = 101,
    localparam int IDX_W = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_addr,
    input  logic              step,
    output logic [DATA_W-1:0] frame_addr,
    output logic [IDX_W-1:0]  word_idx,
    output logic              any_frame
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_addr <= '0;
            word_idx   <= '0;
            any_frame  <= 1'b0;
        end else if (load) begin
            frame_addr <= load_addr;
            word_idx   <= '0;
        end else if (step) begin
            if (word_idx == LAST_IDX) begin
                word_idx   <= '0;
                frame_addr <= frame_addr + 1'b1;
                any_frame  <= 1'b1;
            end else begin
                word_idx <= word_idx + 1'b1;
            end
        end
    end

    assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
        word_idx <= LAST_IDX);
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_addr != $past(frame_addr)) |-> ($past(load) || $past(step)));
endmodule

// File: rtl/cfg_startup_ctr.sv
module cfg_startup_ctr #(
    parameter int STUP_PHASES = 8,
    localparam int PW = $clog2(STUP_PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    output logic [PW-1:0] phase,
    output logic          done
);
    localparam logic [PW-1:0] LAST = PW'(STUP_PHASES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            done  <= 1'b0;
        end else if (run && tick && !done) begin
            if (phase == LAST) done  <= 1'b1;
            else               phase <= phase + 1'b1;
        end
    end

    assert_phase_step_R8: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> ($past(run) && $past(tick)));
    assert_done_last_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> phase == LAST);
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import cfg_seq_pkg::*;
#(
    parameter logic [31:0] DEVICE_ID   = 32'h5A17_C0DE,
    parameter int          FRAME_WORDS = 101,
    parameter int          STUP_PHASES = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [4:0]                     wr_addr,
    input  logic [31:0]                    wr_data,
    input  logic                           stup_tick,
    output logic                           wdog_off,
    output logic                           ic_hiz,
    output logic                           ff_activate,
    output logic                           desync,
    output logic                           frame_word_ok,
    output logic [31:0]                    frame_addr,
    output logic [$clog2(FRAME_WORDS)-1:0] word_idx,
    output logic                           stup_done,
    output logic [15:0]                    status
);
    localparam int PW = $clog2(STUP_PHASES);

    phase_e            ph_q, ph_n;
    logic              err_q, set_err;
    logic [3:0]        opt_q, opt_set;
    logic              rel_q, armed_q;
    logic              fr_load, fr_step, ff_p, ds_p, arm_p;
    logic              crc_fold_en, crc_clr;
    logic [DATA_W-1:0] crc_q;
    logic              any_frame;
    logic [PW-1:0]     stup_phase;
    logic [4:0]        cmd;
    cfg_wr_t           wr;

    assign wr  = '{addr: wr_addr, data: wr_data};
    assign cmd = wr_data[4:0];

    always_comb begin
        ph_n        = ph_q;
        set_err     = 1'b0;
        opt_set     = '0;
        fr_load     = 1'b0;
        fr_step     = 1'b0;
        ff_p        = 1'b0;
        ds_p        = 1'b0;
        arm_p       = 1'b0;
        crc_clr     = 1'b0;
        crc_fold_en = 1'b0;
        if (wr_en && !err_q) begin
            crc_fold_en = (wr_addr != RA_CRC) &&
                          !(wr_addr == RA_CMD && cmd == CMD_RCRC);
            unique case (wr_addr)
                RA_CRC: set_err = (wr_data != crc_q);
                RA_ID: begin
                    if (ph_q == PH_WAIT_ID && wr_data == DEVICE_ID) ph_n = PH_SETUP;
                    else set_err = 1'b1;
                end
                RA_OPT: begin
                    if (ph_q == PH_SETUP) opt_set = wr_data[3:0];
                    else set_err = 1'b1;
                end
                RA_FAR: begin
                    if (ph_q == PH_SETUP && (&opt_q)) begin
                        fr_load = 1'b1;
                        ph_n    = PH_ADDR;
                    end else set_err = 1'b1;
                end
                RA_FDI: begin
                    if (ph_q == PH_WRITE) fr_step = 1'b1;
                    else set_err = 1'b1;
                end
                RA_CMD: begin
                    unique case (cmd)
                        CMD_RCRC: crc_clr = 1'b1;
                        CMD_WCFG: begin
                            if (ph_q == PH_ADDR) ph_n = PH_WRITE;
                            else set_err = 1'b1;
                        end
                        CMD_ACT: begin
                            if (ph_q == PH_WRITE && word_idx == '0 && any_frame) begin
                                ff_p = 1'b1;
                                ph_n = PH_ACTIVE;
                            end else set_err = 1'b1;
                        end
                        CMD_START: begin
                            if (ph_q == PH_ACTIVE) begin
                                arm_p = 1'b1;
                                ph_n  = PH_ARMED;
                            end else set_err = 1'b1;
                        end
                        CMD_DESYNC: begin
                            if (ph_q == PH_ARMED) begin
                                ds_p = 1'b1;
                                ph_n = PH_STARTUP;
                            end else set_err = 1'b1;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
            if (set_err) ph_n = ph_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q          <= PH_WAIT_ID;
            err_q         <= 1'b0;
            opt_q         <= '0;
            rel_q         <= 1'b0;
            armed_q       <= 1'b0;
            ff_activate   <= 1'b0;
            desync        <= 1'b0;
            frame_word_ok <= 1'b0;
        end else begin
            ph_q          <= ph_n;
            err_q         <= err_q | set_err;
            opt_q         <= opt_q | opt_set;
            rel_q         <= rel_q | ff_p;
            armed_q       <= armed_q | arm_p;
            ff_activate   <= ff_p;
            desync        <= ds_p;
            frame_word_ok <= fr_step;
        end
    end

    cfg_crc_acc u_crc (
        .clk(clk), .rst(rst), .fold(crc_fold_en), .clear(crc_clr),
        .wr(wr), .crc_q(crc_q)
    );

    cfg_frame_ctr #(.FRAME_WORDS(FRAME_WORDS)) u_frame (
        .clk(clk), .rst(rst), .load(fr_load), .load_addr(wr_data), .step(fr_step),
        .frame_addr(frame_addr), .word_idx(word_idx), .any_frame(any_frame)
    );

    cfg_startup_ctr #(.STUP_PHASES(STUP_PHASES)) u_stup (
        .clk(clk), .rst(rst), .run(ph_q == PH_STARTUP && !err_q),
        .tick(stup_tick), .phase(stup_phase), .done(stup_done)
    );

    assign wdog_off = opt_q[0];
    assign ic_hiz   = opt_q[3] & ~rel_q;
    assign status   = {5'b0, armed_q, ic_hiz, wdog_off, err_q, stup_done,
                       3'(stup_phase), ph_q};

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        $past(err_q) |-> err_q);
    assert_frame_gate_R11: assert property (@(posedge clk) disable iff (rst)
        frame_word_ok |-> ($past(ph_q) == PH_WRITE && !$past(err_q)));
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(ff_activate && desync));
    assert_desync_order_R7: assert property (@(posedge clk) disable iff (rst)
        desync |-> $past(ph_q) == PH_ARMED);
    assert_activate_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        ff_activate |-> ($past(word_idx) == '0 && $past(any_frame)));
endmodule

// File: tb/tb_cfg_seq_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_seq_ctrl;
    localparam logic [31:0] DEV  = 32'h5A17_C0DE;
    localparam logic [31:0] POLY = 32'h1EDC6F41;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        stup_tick = 1'b0;
    logic        wdog_off, ic_hiz, ff_activate, desync, frame_word_ok, stup_done;
    logic [31:0] frame_addr;
    logic [6:0]  word_idx;
    logic [15:0] status;

    int checks = 0;
    int errors = 0;
    logic [31:0] crc_m = '0;
    int fwo_cnt = 0;

    always #4 clk = ~clk;

    cfg_seq_ctrl #(.DEVICE_ID(DEV)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stup_tick(stup_tick), .wdog_off(wdog_off), .ic_hiz(ic_hiz),
        .ff_activate(ff_activate), .desync(desync), .frame_word_ok(frame_word_ok),
        .frame_addr(frame_addr), .word_idx(word_idx), .stup_done(stup_done),
        .status(status)
    );

    // {addr, data, expected phase, expected error}
    localparam int NV = 7;
    localparam logic [40:0] VEC [NV] = '{
        {5'd12, DEV,          3'd1, 1'b0},
        {5'd9,  32'h0000_0001, 3'd1, 1'b0},
        {5'd9,  32'h0000_0006, 3'd1, 1'b0},
        {5'd7,  32'h1234_5678, 3'd1, 1'b0},
        {5'd9,  32'h0000_0008, 3'd1, 1'b0},
        {5'd1,  32'h0000_0100, 3'd2, 1'b0},
        {5'd4,  32'h0000_0001, 3'd3, 1'b0}
    };

    function automatic logic [31:0] crc_next(input logic [31:0] c, input logic [36:0] v);
        logic [31:0] r = c;
        for (int i = 36; i >= 0; i--) begin
            logic fb = r[31] ^ v[i];
            r = {r[30:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; stup_tick = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        crc_m = '0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (a != 5'd0 && !(a == 5'd4 && d[4:0] == 5'd3)) crc_m = crc_next(crc_m, {a, d});
        if (a == 5'd4 && d[4:0] == 5'd3) crc_m = '0;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (frame_word_ok) fwo_cnt++;
    endtask

    task automatic tick();
        @(negedge clk);
        stup_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stup_tick = 1'b0;
    endtask

    task automatic setup_to_write();
        for (int i = 0; i < NV; i++) wr(VEC[i][40:36], VEC[i][35:4]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 status", 32'(status), 32'h0);
        check("R1 strobes", {28'b0, wdog_off, ic_hiz, ff_activate, desync}, 32'h0);
        check("R1 frame", frame_addr | 32'(word_idx) | 32'(stup_done), 32'h0);

        // table walk: R2 R3 R4 R12
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][40:36], VEC[i][35:4]);
            check("R2/R4 phase", 32'(status[2:0]), 32'(VEC[i][3:1]));
            check("R11 err", 32'(status[7]), 32'(VEC[i][0]));
        end
        check("R3 wdog_off", 32'(wdog_off), 32'd1);
        check("R3 ic_hiz", 32'(ic_hiz), 32'd1);
        check("R12 status bits", 32'(status[15:8]), 32'h03);

        // R5 frame words
        fwo_cnt = 0;
        wr(5'd2, 32'hA5A5_0000);
        check("R5 pulse", 32'(frame_word_ok), 32'd1);
        check("R5 idx", 32'(word_idx), 32'd1);
        for (int k = 1; k < 101; k++) wr(5'd2, 32'hA5A5_0000 + k);
        check("R5 wrap idx", 32'(word_idx), 32'd0);
        check("R5 addr inc", frame_addr, 32'h101);
        for (int k = 0; k < 101; k++) wr(5'd2, 32'h0F0F_0000 ^ k);
        check("R5 addr second", frame_addr, 32'h102);
        check("R5 pulse count", 32'(fwo_cnt), 32'd202);

        // R9 CRC check matches, R10 clear
        wr(5'd0, crc_m);
        check("R9 crc match", 32'(status[7]), 32'd0);
        wr(5'd4, 32'd3);
        wr(5'd0, 32'h0);
        check("R10 cleared", 32'(status[7]), 32'd0);

        // R8 tick before startup ignored
        tick();
        check("R8 early tick", 32'(status[5:3]), 32'd0);

        // R6 activate
        wr(5'd4, 32'd10);
        check("R6 ff pulse", 32'(ff_activate), 32'd1);
        check("R6 hiz off", 32'(ic_hiz), 32'd0);
        check("R6 phase", 32'(status[2:0]), 32'd4);
        // R7 start, desync
        wr(5'd4, 32'd5);
        check("R7 armed", 32'(status[10]), 32'd1);
        check("R7 phase5", 32'(status[2:0]), 32'd5);
        check("R7 no desync yet", 32'(desync), 32'd0);
        wr(5'd4, 32'd13);
        check("R7 desync pulse", 32'(desync), 32'd1);
        check("R7 phase6", 32'(status[2:0]), 32'd6);
        // R8 startup ticks
        for (int t = 1; t <= 7; t++) begin
            tick();
            check("R8 phase", 32'(status[5:3]), 32'(t));
            check("R8 not done", 32'(stup_done), 32'd0);
        end
        tick();
        check("R8 done", 32'(stup_done), 32'd1);
        check("R12 done bit", 32'(status[6]), 32'd1);
        check("R11 clean", 32'(status[7]), 32'd0);

        // R2 wrong id, R11 sticky
        do_reset();
        wr(5'd12, DEV ^ 32'h1);
        check("R2 mismatch err", 32'(status[7]), 32'd1);
        check("R2 phase stays", 32'(status[2:0]), 32'd0);
        wr(5'd12, DEV);
        check("R11 frozen", 32'(status[2:0]), 32'd0);
        check("R11 still err", 32'(status[7]), 32'd1);

        // R3 frame address before full setup
        do_reset();
        wr(5'd12, DEV);
        wr(5'd9, 32'h7);
        check("R3 hiz not set", 32'(ic_hiz), 32'd0);
        wr(5'd1, 32'h40);
        check("R3 early far err", 32'(status[7]), 32'd1);
        check("R3 phase", 32'(status[2:0]), 32'd1);

        // R4 command 1 before frame address
        do_reset();
        wr(5'd12, DEV);
        wr(5'd9, 32'hF);
        wr(5'd4, 32'd1);
        check("R4 wcfg early", 32'(status[7]), 32'd1);

        // R4 data word in setup
        do_reset();
        wr(5'd12, DEV);
        wr(5'd2, 32'h1);
        check("R4 data early", 32'(status[7]), 32'd1);
        check("R4 no pulse", 32'(frame_word_ok), 32'd0);

        // R6 activate at partial frame; R11 data blocked
        do_reset();
        setup_to_write();
        for (int k = 0; k < 101; k++) wr(5'd2, k);
        for (int k = 0; k < 50; k++) wr(5'd2, k);
        wr(5'd4, 32'd10);
        check("R6 partial err", 32'(status[7]), 32'd1);
        check("R6 no ff pulse", 32'(ff_activate), 32'd0);
        wr(5'd2, 32'h55);
        check("R11 data blocked", 32'(frame_word_ok), 32'd0);
        check("R11 idx held", 32'(word_idx), 32'd50);

        // R6 activate with no full frame
        do_reset();
        setup_to_write();
        wr(5'd4, 32'd10);
        check("R6 no frame err", 32'(status[7]), 32'd1);

        // R7 desync before start
        do_reset();
        setup_to_write();
        for (int k = 0; k < 101; k++) wr(5'd2, k);
        wr(5'd4, 32'd10);
        wr(5'd4, 32'd13);
        check("R7 early desync err", 32'(status[7]), 32'd1);
        check("R7 no desync pulse", 32'(desync), 32'd0);

        // R9 bad CRC
        do_reset();
        wr(5'd12, DEV);
        wr(5'd0, crc_m ^ 32'h8000_0000);
        check("R9 crc mismatch", 32'(status[7]), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule